// File: doc/BRIEF.md
# Phase-Control Firing List Builder

This block turns eight per-channel dimmer levels into a sorted list of firing events for one mains half-cycle. Software or a neighbouring block loads a 7-bit level for each load channel into a small register bank, then pulses a build strobe. The builder takes a private copy of the levels and orders the channels from brightest to dimmest. Channels that ask for the same level are grouped together. The result is a short list that a playback timer can walk from the zero crossing onwards.

Each list entry holds an 8-bit channel pattern and a relative delay in level-step ticks. The half-cycle is cut into 128 slots. A channel at level L fires at slot 127 − L, so level 127 fires at once and level 0 never fires. Entry 0 always has an empty pattern, and its delay runs up to the first firing group. Every later entry's delay runs up to the next group, or to slot 128 for the last one.

The list sits in two banks. Readers see the finished bank while the other one fills, and the banks swap in the cycle the build completes. Completion raises a done flag.

Top module: `fire_list_builder`

## Requirements
- R1: After reset, busy and done are 0 and entry_count is 1. Entry 0 reads pattern 0x00 with delay 128, and every other address reads zero.
- R2: A cycle with lvl_we high stores lvl_wdata as the level of channel lvl_addr. The next accepted build uses that value.
- R3: A build strobe seen while busy is 0 is accepted. busy is 1 and done is 0 in the following cycle. A build strobe seen while busy is 1 is ignored: the running build neither restarts nor changes its result.
- R4: Entry 0 always has pattern 0x00. Its delay is 127 minus the highest nonzero level. When every level is 0, the list is entry 0 alone with delay 128 and entry_count is 1.
- R5: Entries 1 and up appear in strictly decreasing level order. Bit i of a pattern stands for channel i.
- R6: All channels with the same nonzero level share one entry. Level 0 channels appear in no entry. No channel appears twice, and entry_count equals 1 plus the number of distinct nonzero levels.
- R7: The delay of entry k equals the slot of entry k+1's group minus the slot of entry k's group, with entry 0 at slot 0. The last entry's delay runs to slot 128, so all delays add up to 128.
- R8: done rises exactly 8 × entry_count cycles after the clock edge that accepted the build. This is at most 72 cycles.
- R9: Until done rises, the read port and entry_count keep showing the previous list. The build uses the levels held at the accepting edge, so a level write in that same cycle or during the build does not affect it.
- R10: A read at an address at or above entry_count returns pattern 0 and delay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_we | input | 1 | Level write enable |
| lvl_addr | input | 3 | Channel being written |
| lvl_wdata | input | 7 | Level value to store |
| build | input | 1 | Build strobe |
| rd_addr | input | 4 | List read address |
| busy | output | 1 | Build in progress |
| done | output | 1 | Last build finished; clears on the next accepted build |
| entry_count | output | 4 | Number of valid entries in the visible list |
| rd_pattern | output | 8 | Channel pattern at rd_addr |
| rd_delay | output | 8 | Relative delay at rd_addr, in slots |

## Verification
Two kinds of input can meet the build engine in the same cycle. One is a level write landing on the edge that accepts a build. The other is a second build strobe arriving while a long build is still scanning. The bench provokes the first by raising lvl_we and build together, and the second by pulsing build and rewriting a level partway through an eight-group build. Both are judged against lists computed by the bench from the levels held before the write, along with the exact completion latency of the untouched build. The checker also confirms that the visible count stays put while the banks are still filling.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_SCAN = 1'b1
  } eng_state_t;

  // Absolute firing slot of a level: the brightest level fires first.
  function automatic int fl_slot(input int lvl, input int lvl_w);
    return (2 ** lvl_w) - 1 - lvl;
  endfunction

  // Cycles a build takes for a list with n_entries entries.
  function automatic int fl_latency(input int n_entries, input int n_ch);
    return n_ch * n_entries;
  endfunction

endpackage

// File: rtl/fl_level_bank.sv
module fl_level_bank #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 7,
  localparam int CH_AW = $clog2(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [CH_AW-1:0]        addr,
  input  logic [LVL_W-1:0]        wdata,
  output logic [N_CH*LVL_W-1:0]   levels
);

  logic [LVL_W-1:0] lvl_q [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) lvl_q[i] <= '0;
    end else if (we) begin
      lvl_q[addr] <= wdata;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_flat
    assign levels[g*LVL_W +: LVL_W] = lvl_q[g];
  end

endmodule

// File: rtl/fl_sort_engine.sv
module fl_sort_engine #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 7,
  localparam int CH_AW = $clog2(N_CH),
  localparam int DEPTH = N_CH + 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int DLY_W = LVL_W + 1,
  localparam int SLOTS = 1 << LVL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_req,
  input  logic [N_CH*LVL_W-1:0]   levels,
  output logic                    busy,
  output logic                    accept,
  output logic                    commit,
  output logic                    wr_pat_en,
  output logic [AW-1:0]           wr_pat_idx,
  output logic [N_CH-1:0]         wr_pat,
  output logic                    wr_dly_en,
  output logic [AW-1:0]           wr_dly_idx,
  output logic [DLY_W-1:0]        wr_dly,
  output logic [CW-1:0]           wr_cnt
);
  import fl_pkg::*;

  eng_state_t       state_q;
  logic [LVL_W-1:0] snap_q [N_CH];
  logic [CH_AW-1:0] idx_q;
  logic [DLY_W-1:0] ceil_q;      // exclusive upper bound on this pass
  logic [LVL_W-1:0] best_q;
  logic [N_CH-1:0]  mask_q;
  logic [AW-1:0]    k_q;         // index of the newest entry
  logic [DLY_W-1:0] prev_slot_q;

  logic [LVL_W-1:0] cand;
  logic             elig;
  logic [LVL_W-1:0] nb;
  logic [N_CH-1:0]  nm;
  logic             last_ch;
  logic             pass_end;
  logic             found;
  logic [DLY_W-1:0] new_slot;

  always_comb begin
    cand = snap_q[idx_q];
    elig = (cand != '0) && ({1'b0, cand} < ceil_q);
    nb   = best_q;
    nm   = mask_q;
    if (elig && cand > best_q) begin
      nb      = cand;
      nm      = '0;
      nm[idx_q] = 1'b1;
    end else if (elig && cand == best_q) begin
      nm[idx_q] = 1'b1;
    end
  end

  assign busy     = (state_q == ENG_SCAN);
  assign last_ch  = (idx_q == CH_AW'(N_CH - 1));
  assign pass_end = busy && last_ch;
  assign found    = (nb != '0);
  assign new_slot = DLY_W'(fl_slot(int'(nb), LVL_W));

  assign accept     = start_req && !busy;
  assign commit     = pass_end && !found;
  assign wr_pat_en  = accept || (pass_end && found);
  assign wr_pat_idx = accept ? '0 : k_q + AW'(1);
  assign wr_pat     = accept ? '0 : nm;
  assign wr_dly_en  = pass_end;
  assign wr_dly_idx = k_q;
  assign wr_dly     = found ? (new_slot - prev_slot_q) : (DLY_W'(SLOTS) - prev_slot_q);
  assign wr_cnt     = CW'(k_q) + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ENG_IDLE;
      idx_q       <= '0;
      ceil_q      <= '0;
      best_q      <= '0;
      mask_q      <= '0;
      k_q         <= '0;
      prev_slot_q <= '0;
      for (int i = 0; i < N_CH; i++) snap_q[i] <= '0;
    end else if (accept) begin
      state_q     <= ENG_SCAN;
      idx_q       <= '0;
      ceil_q      <= DLY_W'(SLOTS);
      best_q      <= '0;
      mask_q      <= '0;
      k_q         <= '0;
      prev_slot_q <= '0;
      for (int i = 0; i < N_CH; i++) snap_q[i] <= levels[i*LVL_W +: LVL_W];
    end else if (busy) begin
      if (last_ch) begin
        idx_q  <= '0;
        best_q <= '0;
        mask_q <= '0;
        if (found) begin
          k_q         <= k_q + AW'(1);
          prev_slot_q <= new_slot;
          ceil_q      <= {1'b0, nb};
        end else begin
          state_q <= ENG_IDLE;
        end
      end else begin
        idx_q  <= idx_q + CH_AW'(1);
        best_q <= nb;
        mask_q <= nm;
      end
    end
  end

endmodule

// File: rtl/fl_list_store.sv
module fl_list_store #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 7,
  localparam int DEPTH = N_CH + 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int DLY_W = LVL_W + 1,
  localparam int SLOTS = 1 << LVL_W,
  localparam int NBANK = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_pat_en,
  input  logic [AW-1:0]      wr_pat_idx,
  input  logic [N_CH-1:0]    wr_pat,
  input  logic               wr_dly_en,
  input  logic [AW-1:0]      wr_dly_idx,
  input  logic [DLY_W-1:0]   wr_dly,
  input  logic               commit,
  input  logic [CW-1:0]      wr_cnt,
  input  logic [AW-1:0]      rd_addr,
  output logic [CW-1:0]      rd_cnt,
  output logic [N_CH-1:0]    rd_pat,
  output logic [DLY_W-1:0]   rd_dly
);

  logic [N_CH-1:0]  pat_q [NBANK][DEPTH];
  logic [DLY_W-1:0] dly_q [NBANK][DEPTH];
  logic [CW-1:0]    cnt_q [NBANK];
  logic             act_q;       // bank seen by readers
  logic             wb;          // bank being filled
  logic             rd_hit;

  assign wb = ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        cnt_q[b] <= CW'(1);
        for (int e = 0; e < DEPTH; e++) begin
          pat_q[b][e] <= '0;
          dly_q[b][e] <= (e == 0) ? DLY_W'(SLOTS) : '0;
        end
      end
    end else begin
      if (wr_pat_en) pat_q[wb][wr_pat_idx] <= wr_pat;
      if (wr_dly_en) dly_q[wb][wr_dly_idx] <= wr_dly;
      if (commit) begin
        cnt_q[wb] <= wr_cnt;
        act_q     <= wb;
      end
    end
  end

  assign rd_cnt = cnt_q[act_q];
  assign rd_hit = (CW'(rd_addr) < cnt_q[act_q]);
  assign rd_pat = rd_hit ? pat_q[act_q][rd_addr] : '0;
  assign rd_dly = rd_hit ? dly_q[act_q][rd_addr] : '0;

endmodule

// File: rtl/fire_list_builder.sv
module fire_list_builder #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 7,
  localparam int CH_AW = $clog2(N_CH),
  localparam int DEPTH = N_CH + 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int DLY_W = LVL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_we,
  input  logic [CH_AW-1:0]  lvl_addr,
  input  logic [LVL_W-1:0]  lvl_wdata,
  input  logic              build,
  input  logic [AW-1:0]     rd_addr,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     entry_count,
  output logic [N_CH-1:0]   rd_pattern,
  output logic [DLY_W-1:0]  rd_delay
);

  logic [N_CH*LVL_W-1:0] levels;
  logic                  accept;
  logic                  commit;
  logic                  wr_pat_en;
  logic [AW-1:0]         wr_pat_idx;
  logic [N_CH-1:0]       wr_pat;
  logic                  wr_dly_en;
  logic [AW-1:0]         wr_dly_idx;
  logic [DLY_W-1:0]      wr_dly;
  logic [CW-1:0]         wr_cnt;

  fl_level_bank #(.N_CH(N_CH), .LVL_W(LVL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (lvl_we),
    .addr   (lvl_addr),
    .wdata  (lvl_wdata),
    .levels (levels)
  );

  fl_sort_engine #(.N_CH(N_CH), .LVL_W(LVL_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (build),
    .levels     (levels),
    .busy       (busy),
    .accept     (accept),
    .commit     (commit),
    .wr_pat_en  (wr_pat_en),
    .wr_pat_idx (wr_pat_idx),
    .wr_pat     (wr_pat),
    .wr_dly_en  (wr_dly_en),
    .wr_dly_idx (wr_dly_idx),
    .wr_dly     (wr_dly),
    .wr_cnt     (wr_cnt)
  );

  fl_list_store #(.N_CH(N_CH), .LVL_W(LVL_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_pat_en  (wr_pat_en),
    .wr_pat_idx (wr_pat_idx),
    .wr_pat     (wr_pat),
    .wr_dly_en  (wr_dly_en),
    .wr_dly_idx (wr_dly_idx),
    .wr_dly     (wr_dly),
    .commit     (commit),
    .wr_cnt     (wr_cnt),
    .rd_addr    (rd_addr),
    .rd_cnt     (entry_count),
    .rd_pat     (rd_pattern),
    .rd_dly     (rd_delay)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      done <= 1'b0;
    else if (accept) done <= 1'b0;
    else if (commit) done <= 1'b1;
  end

endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 7,
  localparam int DEPTH = N_CH + 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int DLY_W = LVL_W + 1,
  localparam int SLOTS = 1 << LVL_W,
  localparam int MAXRUN = N_CH * DEPTH,
  localparam int RW    = $clog2(MAXRUN + 2),
  localparam int SW    = $clog2(SLOTS * DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             build,
  input logic             busy,
  input logic             done,
  input logic [CW-1:0]    entry_count,
  input logic             accept,
  input logic             commit,
  input logic             wr_pat_en,
  input logic [N_CH-1:0]  wr_pat,
  input logic             wr_dly_en,
  input logic [DLY_W-1:0] wr_dly
);

  logic [RW-1:0]   run_q;
  logic [N_CH-1:0] seen_q;
  logic [SW-1:0]   sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= '0;
      sum_q  <= '0;
    end else if (accept) begin
      run_q  <= '0;
      seen_q <= '0;
      sum_q  <= '0;
    end else begin
      if (busy && run_q < RW'(MAXRUN + 1)) run_q <= run_q + RW'(1);
      if (wr_pat_en) seen_q <= seen_q | wr_pat;
      if (wr_dly_en) sum_q  <= sum_q + SW'(wr_dly);
    end
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (build && !busy) |=> (busy && !done)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_LIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(entry_count)); // R9
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_count >= CW'(1)) && (entry_count <= CW'(DEPTH))); // R6
  AST_GROUP_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pat_en && !accept) |-> ((wr_pat & seen_q) == '0) && (wr_pat != '0)); // R6
  AST_DELAY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (sum_q + SW'(wr_dly) == SW'(SLOTS))); // R7
  AST_BOUNDED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RW'(MAXRUN))); // R8

endmodule

bind fire_list_builder fl_checker #(.N_CH(N_CH), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .build       (build),
  .busy        (busy),
  .done        (done),
  .entry_count (entry_count),
  .accept      (accept),
  .commit      (commit),
  .wr_pat_en   (wr_pat_en),
  .wr_pat      (wr_pat),
  .wr_dly_en   (wr_dly_en),
  .wr_dly      (wr_dly)
);

// File: tb/fire_list_builder_tb.sv
`timescale 1ns/1ps
module fire_list_builder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lvl_we = 1'b0;
  logic [2:0] lvl_addr = '0;
  logic [6:0] lvl_wdata = '0;
  logic       build = 1'b0;
  logic [3:0] rd_addr = '0;
  logic       busy, done;
  logic [3:0] entry_count;
  logic [7:0] rd_pattern, rd_delay;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [6:0] mdl [8];
  logic [6:0] snap [8];
  int exp_cnt;
  int exp_pat [16];
  int exp_dly [16];
  int t0;

  fire_list_builder u_dut (
    .clk(clk), .rst_n(rst_n), .lvl_we(lvl_we), .lvl_addr(lvl_addr),
    .lvl_wdata(lvl_wdata), .build(build), .rd_addr(rd_addr), .busy(busy),
    .done(done), .entry_count(entry_count), .rd_pattern(rd_pattern),
    .rd_delay(rd_delay)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Expected list from a walk over the slots, brightest first.
  function automatic void make_expect();
    int last = 0;
    for (int i = 0; i < 16; i++) begin exp_pat[i] = 0; exp_dly[i] = 0; end
    exp_cnt = 1;
    for (int s = 0; s < 128; s++) begin
      int m = 0;
      for (int c = 0; c < 8; c++)
        if (snap[c] != 0 && 127 - int'(snap[c]) == s) m |= (1 << c);
      if (m != 0) begin
        exp_dly[exp_cnt-1] = s - last;
        exp_pat[exp_cnt] = m;
        exp_cnt++;
        last = s;
      end
    end
    exp_dly[exp_cnt-1] = 128 - last;
  endfunction

  task automatic wr_lvl(input int ch, input int v);
    lvl_we = 1'b1; lvl_addr = 3'(ch); lvl_wdata = 7'(v);
    @(negedge clk);
    lvl_we = 1'b0;
    mdl[ch] = 7'(v);
  endtask

  task automatic check_list(input string req);
    chk(int'(entry_count) == exp_cnt, req, "entry_count", int'(entry_count), exp_cnt);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #1;
      chk(int'(rd_pattern) == exp_pat[a], (a < exp_cnt) ? req : "R10",
          $sformatf("pattern[%0d]", a), int'(rd_pattern), exp_pat[a]);
      chk(int'(rd_delay) == exp_dly[a], (a < exp_cnt) ? req : "R10",
          $sformatf("delay[%0d]", a), int'(rd_delay), exp_dly[a]);
      @(negedge clk);
    end
  endtask

  // Pulse build; returns at the negedge after the accepting edge.
  task automatic start_build(input bit with_write, input int ch, input int v);
    for (int c = 0; c < 8; c++) snap[c] = mdl[c];
    build = 1'b1;
    if (with_write) begin
      lvl_we = 1'b1; lvl_addr = 3'(ch); lvl_wdata = 7'(v);
    end
    @(negedge clk);
    build = 1'b0;
    lvl_we = 1'b0;
    if (with_write) mdl[ch] = 7'(v);
    t0 = cyc;
    chk(busy == 1'b1 && done == 1'b0, "R3", "busy/done after accept",
        int'({busy, done}), 2);
  endtask

  task automatic finish_build(input string req);
    int lat;
    while (!done && (cyc - t0) < 300) @(negedge clk);
    lat = cyc - t0;
    make_expect();
    chk(lat == 8 * exp_cnt, "R8", "latency", lat, 8 * exp_cnt);
    check_list(req);
  endtask

  task automatic load_all(input int v0, input int v1, input int v2, input int v3,
                          input int v4, input int v5, input int v6, input int v7);
    wr_lvl(0, v0); wr_lvl(1, v1); wr_lvl(2, v2); wr_lvl(3, v3);
    wr_lvl(4, v4); wr_lvl(5, v5); wr_lvl(6, v6); wr_lvl(7, v7);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 8; c++) mdl[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done at reset", int'({busy, done}), 0);
    for (int c = 0; c < 8; c++) snap[c] = '0;
    make_expect();
    check_list("R1");

    // R4: nothing lit
    load_all(0, 0, 0, 0, 0, 0, 0, 0);
    start_build(1'b0, 0, 0); finish_build("R4");

    // R4 R6: everything full on, one merged group at slot 0
    load_all(127, 127, 127, 127, 127, 127, 127, 127);
    start_build(1'b0, 0, 0); finish_build("R4");
    chk(exp_cnt == 2 && exp_dly[0] == 0 && exp_pat[1] == 8'hFF, "R6", "model full-on", exp_cnt, 2);

    // R7: single dim channel, long first delay
    load_all(0, 0, 0, 0, 0, 1, 0, 0);
    start_build(1'b0, 0, 0); finish_build("R7");

    // R5: eight distinct levels, worst-case length
    load_all(10, 90, 3, 127, 64, 50, 100, 1);
    start_build(1'b0, 0, 0); finish_build("R5");

    // R6: pairs sharing levels, some zeros
    load_all(40, 0, 40, 99, 0, 99, 7, 7);
    start_build(1'b0, 0, 0); finish_build("R6");

    // R9 R3: read port held during a long build; extra strobe and write ignored
    load_all(1, 2, 3, 4, 5, 6, 7, 8);
    start_build(1'b0, 0, 0);
    repeat (4) @(negedge clk);
    chk(int'(entry_count) == exp_cnt, "R9", "count held while busy", int'(entry_count), exp_cnt);
    rd_addr = 4'(1); #1;
    chk(int'(rd_pattern) == exp_pat[1], "R9", "entry 1 held while busy", int'(rd_pattern), exp_pat[1]);
    @(negedge clk);
    build = 1'b1;
    @(negedge clk);
    build = 1'b0;
    wr_lvl(0, 120);
    finish_build("R3");
    // R2: the write made during the build counts for the next one
    start_build(1'b0, 0, 0); finish_build("R2");

    // R9: write on the accepting edge is not part of that build
    load_all(30, 30, 30, 30, 30, 30, 30, 30);
    start_build(1'b1, 4, 90); finish_build("R9");
    start_build(1'b0, 0, 0); finish_build("R2");

    // Random mix with forced collisions and extremes
    for (int it = 0; it < 60; it++) begin
      for (int c = 0; c < 8; c++) begin
        int sel = int'($urandom % 4);
        int v;
        if (sel == 0)      v = 0;
        else if (sel == 1) v = 127;
        else if (sel == 2) v = int'($urandom % 8) * 16 + 3;
        else               v = int'($urandom % 128);
        wr_lvl(c, v);
      end
      start_build(1'b0, 0, 0);
      finish_build("R5");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule